// File: doc/BRIEF.md
# Coherence Transition Checker

This block runs next to a cache controller and audits its coherence activity while the system is running. Each time the controller finishes a change of line state, it hands the checker a record. The record holds the line address, the state the controller believes it started from, the state it ended in, the event that triggered the change and the action it took. The checker keeps its own direct-mapped copy of the stable MSI state of each line, called the architected state. A small reference protocol recomputes what the controller should have done, and the checker compares that result with the report.

A record that agrees with the reference updates the architected copy. If its state change is one that other nodes must learn about, the record also queues a coherence assertion for a validation bus. A record that disagrees raises an error with a diagnosis code and leaves the architected copy untouched. A watchdog counts cycles while the controller reports an outstanding request. It raises a timeout when no transition is accepted within a programmable limit.

The control path is a two-state machine. In `ST_IDLE` the block offers `tr_ready` and latches a record on a handshake, taking transition `IDLE->CHECK`. In `ST_CHECK` it reads the architected entry, compares the record with the reference, updates the entry and queues an assertion if needed, and then always takes transition `CHECK->IDLE`.

Top module: `coh_xchk`

## Requirements
- R1: After reset `tr_ready`=1, `as_valid`=0 and `err_valid`=0. Every architected entry reads as Invalid. States are encoded I=0, S=1, M=2.
- R2: The reference protocol uses events RD=0 (local read), WR=1 (local write), SNRD=2 (snooped read), SNRDX=3 (snooped read-exclusive), EVICT=4 (replacement). It uses actions NONE=0, FETCH_SH=1, FETCH_EX=2, SUPPLY=3. The transitions are:
  - From I: RD gives S with FETCH_SH, and WR gives M with FETCH_EX.
  - From S: WR gives M with FETCH_EX, and SNRDX or EVICT gives I.
  - From M: SNRD gives S with SUPPLY, and SNRDX or EVICT gives I with SUPPLY.
  - Every other pair keeps the state with NONE.
  A record that matches the reference raises no error.
- R3: If the reported initial state differs from the architected state, the block gives `err_code`=1. This code outranks all other checks.
- R4: If the initial state matches but the reported final state differs from the reference, the block gives `err_code`=2.
- R5: If both states match but the reported action differs from the reference, the block gives `err_code`=3.
- R6: Only a record with no error writes its final state into the architected entry. A failed record leaves the entry unchanged.
- R7: A passing record queues an assertion carrying its address and a kind for four changes only: I to S gives kind 0, I to M gives kind 1, S to M gives kind 2, and M to I gives kind 3.
- R8: A passing record that changes M to S, changes S to I, or keeps its state queues no assertion.
- R9: When the assertion buffer is full, `tr_ready` is 0, and no record is accepted until an assertion leaves.
- R10: The watchdog counts cycles while `pend_req`=1. It restarts on every accepted record and whenever `pend_req`=0. After `wd_limit` counted cycles it gives one pulse of `err_valid` with `err_code`=4. The limit must be 2 or more.
- R11: Each index holds one tag. A passing record for a new tag at that index replaces the old line, and the old line then reads as Invalid.
- R12: Assertions leave in the order they were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tr_valid | input | 1 | Transition record offered |
| tr_ready | output | 1 | Checker can accept a record |
| tr_addr | input | AW | Line address |
| tr_init | input | 2 | Reported initial state |
| tr_final | input | 2 | Reported final state |
| tr_event | input | 3 | Triggering event |
| tr_action | input | 2 | Reported action |
| pend_req | input | 1 | Controller has an outstanding request |
| wd_limit | input | WDW | Watchdog limit in cycles |
| as_valid | output | 1 | Assertion available for the validation bus |
| as_ready | input | 1 | Validation bus takes the assertion |
| as_addr | output | AW | Assertion address |
| as_kind | output | 2 | Assertion kind |
| err_valid | output | 1 | Error pulse |
| err_code | output | 3 | Diagnosis: 1 initial, 2 final, 3 action, 4 timeout |

## Verification
The bench builds the block with AW=8, IW=2, DEPTH=2 and WDW=8. With only four indexes, two addresses that share an index are easy to pick, so replacement of one line by another comes within reach. A buffer of two entries fills after two stalled assertions, so backpressure can be observed within a few cycles. A watchdog limit of 10 lets both the timeout and its restart on an accepted record be timed to the exact cycle.

// File: rtl/coh_pkg.sv
package coh_pkg;
    localparam logic [1:0] MSI_I = 2'd0;
    localparam logic [1:0] MSI_S = 2'd1;
    localparam logic [1:0] MSI_M = 2'd2;

    localparam logic [2:0] EV_RD    = 3'd0;
    localparam logic [2:0] EV_WR    = 3'd1;
    localparam logic [2:0] EV_SNRD  = 3'd2;
    localparam logic [2:0] EV_SNRDX = 3'd3;
    localparam logic [2:0] EV_EVICT = 3'd4;

    localparam logic [1:0] ACT_NONE     = 2'd0;
    localparam logic [1:0] ACT_FETCH_SH = 2'd1;
    localparam logic [1:0] ACT_FETCH_EX = 2'd2;
    localparam logic [1:0] ACT_SUPPLY   = 2'd3;

    localparam logic [1:0] AK_I2S = 2'd0;
    localparam logic [1:0] AK_I2M = 2'd1;
    localparam logic [1:0] AK_S2M = 2'd2;
    localparam logic [1:0] AK_M2I = 2'd3;

    localparam logic [2:0] ERR_NONE    = 3'd0;
    localparam logic [2:0] ERR_INIT    = 3'd1;
    localparam logic [2:0] ERR_FINAL   = 3'd2;
    localparam logic [2:0] ERR_ACTION  = 3'd3;
    localparam logic [2:0] ERR_TIMEOUT = 3'd4;
endpackage

// File: rtl/coh_ref_msi.sv
module coh_ref_msi
    import coh_pkg::*;
(
    input  logic [1:0] cur,
    input  logic [2:0] ev,
    output logic [1:0] nxt,
    output logic [1:0] act,
    output logic       asrt_en,
    output logic [1:0] asrt_kind
);
    always_comb begin
        nxt = cur;
        act = ACT_NONE;
        unique case (cur)
            MSI_I: begin
                if (ev == EV_RD) begin nxt = MSI_S; act = ACT_FETCH_SH; end
                else if (ev == EV_WR) begin nxt = MSI_M; act = ACT_FETCH_EX; end
            end
            MSI_S: begin
                if (ev == EV_WR) begin nxt = MSI_M; act = ACT_FETCH_EX; end
                else if (ev == EV_SNRDX || ev == EV_EVICT) nxt = MSI_I;
            end
            MSI_M: begin
                if (ev == EV_SNRD) begin nxt = MSI_S; act = ACT_SUPPLY; end
                else if (ev == EV_SNRDX || ev == EV_EVICT) begin
                    nxt = MSI_I;
                    act = ACT_SUPPLY;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        asrt_en   = 1'b1;
        asrt_kind = AK_I2S;
        if (cur == MSI_I && nxt == MSI_S)      asrt_kind = AK_I2S;
        else if (cur == MSI_I && nxt == MSI_M) asrt_kind = AK_I2M;
        else if (cur == MSI_S && nxt == MSI_M) asrt_kind = AK_S2M;
        else if (cur == MSI_M && nxt == MSI_I) asrt_kind = AK_M2I;
        else                                   asrt_en   = 1'b0;
    end
endmodule

// File: rtl/coh_arch_array.sv
module coh_arch_array
    import coh_pkg::*;
#(
    parameter int IW = 4,
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic [TW-1:0] tag,
    output logic [1:0]    rd_state,
    input  logic          we,
    input  logic [1:0]    wr_state
);
    localparam int NSETS = 1 << IW;

    logic [TW-1:0] tags [NSETS];
    logic [1:0]    sts  [NSETS];

    assign rd_state = (tags[idx] == tag) ? sts[idx] : MSI_I;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSETS; i++) begin
                tags[i] <= '0;
                sts[i]  <= MSI_I;
            end
        end else if (we) begin
            tags[idx] <= tag;
            sts[idx]  <= wr_state;
        end
    end
endmodule

// File: rtl/coh_asrt_fifo.sv
module coh_asrt_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                mem[wp] <= din;
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R12
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/coh_watchdog.sv
module coh_watchdog #(
    parameter int WDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           active,
    input  logic [WDW-1:0] limit,
    output logic           timeout
);
    logic [WDW-1:0] cnt;
    logic           fired;

    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active) begin
            cnt     <= '0;
            fired   <= 1'b0;
            timeout <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (!fired) begin
                if (cnt == limit - WDW'(1)) begin
                    timeout <= 1'b1;
                    fired   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    // R10
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !timeout);
endmodule

// File: rtl/coh_xchk.sv
module coh_xchk
    import coh_pkg::*;
#(
    parameter int AW    = 16,
    parameter int IW    = 4,
    parameter int DEPTH = 4,
    parameter int WDW   = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tr_valid,
    output logic           tr_ready,
    input  logic [AW-1:0]  tr_addr,
    input  logic [1:0]     tr_init,
    input  logic [1:0]     tr_final,
    input  logic [2:0]     tr_event,
    input  logic [1:0]     tr_action,
    input  logic           pend_req,
    input  logic [WDW-1:0] wd_limit,
    output logic           as_valid,
    input  logic           as_ready,
    output logic [AW-1:0]  as_addr,
    output logic [1:0]     as_kind,
    output logic           err_valid,
    output logic [2:0]     err_code
);
    localparam int TW = AW - IW;
    localparam int QW = AW + 2;

    typedef enum logic {ST_IDLE, ST_CHECK} fsm_t;
    fsm_t st, st_n;

    logic [AW-1:0] q_addr;
    logic [1:0]    q_init, q_final, q_act;
    logic [2:0]    q_ev;
    logic [1:0]    arch_st, exp_nxt, exp_act, asrt_kind;
    logic          asrt_en, fifo_full, fifo_empty, tr_fire, upd, push, wd_to;
    logic [2:0]    code, code_q;
    logic          err_q;
    logic [QW-1:0] fifo_out;

    assign tr_ready = (st == ST_IDLE) && !fifo_full;
    assign tr_fire  = tr_valid && tr_ready;

    coh_arch_array #(.IW(IW), .TW(TW)) u_arch (
        .clk(clk), .rst_n(rst_n),
        .idx(q_addr[IW-1:0]), .tag(q_addr[AW-1:IW]),
        .rd_state(arch_st), .we(upd), .wr_state(q_final)
    );

    coh_ref_msi u_ref (
        .cur(arch_st), .ev(q_ev), .nxt(exp_nxt), .act(exp_act),
        .asrt_en(asrt_en), .asrt_kind(asrt_kind)
    );

    always_comb begin
        if (q_init != arch_st)       code = ERR_INIT;
        else if (q_final != exp_nxt) code = ERR_FINAL;
        else if (q_act != exp_act)   code = ERR_ACTION;
        else                         code = ERR_NONE;
    end

    assign upd  = (st == ST_CHECK) && (code == ERR_NONE);
    assign push = upd && asrt_en;

    coh_asrt_fifo #(.W(QW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din({q_addr, asrt_kind}), .full(fifo_full),
        .pop(as_valid && as_ready), .dout(fifo_out), .empty(fifo_empty)
    );

    assign as_valid = !fifo_empty;
    assign as_addr  = fifo_out[QW-1:2];
    assign as_kind  = fifo_out[1:0];

    coh_watchdog #(.WDW(WDW)) u_wd (
        .clk(clk), .rst_n(rst_n), .restart(tr_fire), .active(pend_req),
        .limit(wd_limit), .timeout(wd_to)
    );

    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  if (tr_fire) st_n = ST_CHECK;
            ST_CHECK: st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            code_q  <= ERR_NONE;
            q_addr  <= '0;
            q_init  <= MSI_I;
            q_final <= MSI_I;
            q_act   <= ACT_NONE;
            q_ev    <= EV_RD;
        end else begin
            err_q  <= (st == ST_CHECK) && (code != ERR_NONE);
            code_q <= (st == ST_CHECK) ? code : ERR_NONE;
            if (tr_fire) begin
                q_addr  <= tr_addr;
                q_init  <= tr_init;
                q_final <= tr_final;
                q_act   <= tr_action;
                q_ev    <= tr_event;
            end
        end
    end

    assign err_valid = err_q || wd_to;
    assign err_code  = err_q ? code_q : (wd_to ? ERR_TIMEOUT : ERR_NONE);

    // R3
    init_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && q_init != arch_st) |=> (err_valid && err_code == ERR_INIT));

    // R4
    final_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && q_init == arch_st && q_final != exp_nxt)
        |=> (err_valid && err_code == ERR_FINAL));

    // R9
    accept_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tr_fire |=> !tr_ready);

    // R6
    fail_no_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && q_init != arch_st) |=> $stable(as_valid) || !as_valid || as_ready);
endmodule

// File: tb/tb_coh_xchk.sv
module tb_coh_xchk;
    localparam int CLK_NS = 10;
    localparam int AW = 8;
    localparam int WDL = 10;

    logic clk = 0, rst_n = 0;
    logic tr_valid = 0, as_ready = 1, pend_req = 0;
    logic tr_ready, as_valid, err_valid;
    logic [AW-1:0] tr_addr = 0, as_addr;
    logic [1:0] tr_init = 0, tr_final = 0, tr_action = 0, as_kind;
    logic [2:0] tr_event = 0, err_code;
    logic [7:0] wd_limit = 8'(WDL);

    int checks = 0, fails = 0;
    bit done = 0;
    logic [9:0] aq[$];
    logic [2:0] eq[$];
    logic [5:0] mtag [4];
    logic [1:0] mst  [4];

    always #(CLK_NS/2) clk = ~clk;

    coh_xchk #(.AW(AW), .IW(2), .DEPTH(2), .WDW(8)) dut (
        .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_ready(tr_ready),
        .tr_addr(tr_addr), .tr_init(tr_init), .tr_final(tr_final),
        .tr_event(tr_event), .tr_action(tr_action), .pend_req(pend_req),
        .wd_limit(wd_limit), .as_valid(as_valid), .as_ready(as_ready),
        .as_addr(as_addr), .as_kind(as_kind), .err_valid(err_valid),
        .err_code(err_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string code_req(input logic [2:0] c);
        case (c)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R10";
        endcase
    endfunction

    // R2 reference: I=0 S=1 M=2; RD=0 WR=1 SNRD=2 SNRDX=3 EVICT=4
    function automatic void ref_msi(input logic [1:0] c, input logic [2:0] e,
                                    output logic [1:0] n, output logic [1:0] a);
        n = c; a = 2'd0;
        if (c == 2'd0) begin
            if (e == 3'd0) begin n = 2'd1; a = 2'd1; end
            if (e == 3'd1) begin n = 2'd2; a = 2'd2; end
        end else if (c == 2'd1) begin
            if (e == 3'd1) begin n = 2'd2; a = 2'd2; end
            if (e == 3'd3 || e == 3'd4) n = 2'd0;
        end else begin
            if (e == 3'd2) begin n = 2'd1; a = 2'd3; end
            if (e == 3'd3 || e == 3'd4) begin n = 2'd0; a = 2'd3; end
        end
    endfunction

    // corrupt: 0 none, 1 init, 2 final, 3 action, 4 init+final
    task automatic send(input logic [7:0] addr, input logic [2:0] ev, input int corrupt);
        logic [1:0] cur, n, a, ini, fin;
        int ix;
        ix  = int'(addr[1:0]);
        cur = (mtag[ix] == addr[7:2]) ? mst[ix] : 2'd0;
        ref_msi(cur, ev, n, a);
        ini = cur; fin = n;
        if (corrupt == 1 || corrupt == 4) ini = cur ^ 2'b11;
        if (corrupt == 2 || corrupt == 4) fin = (n == 2'd0) ? 2'd1 : 2'd0;
        if (corrupt == 3) a = a ^ 2'b01;
        if (corrupt != 0) begin
            eq.push_back((corrupt == 4) ? 3'd1 : 3'(corrupt));
        end else begin
            mtag[ix] = addr[7:2];
            mst[ix]  = n;
            if (cur == 2'd0 && n == 2'd1) aq.push_back({addr, 2'd0});
            else if (cur == 2'd0 && n == 2'd2) aq.push_back({addr, 2'd1});
            else if (cur == 2'd1 && n == 2'd2) aq.push_back({addr, 2'd2});
            else if (cur == 2'd2 && n == 2'd0) aq.push_back({addr, 2'd3});
        end
        tr_valid = 1; tr_addr = addr; tr_event = ev;
        tr_init = ini; tr_final = fin; tr_action = a;
        while (!tr_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        tr_valid = 0;
    endtask

    // monitor: compares outputs with the scoreboard queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (err_valid) begin
                if (eq.size() == 0) begin
                    chk(0, "R2", int'(err_code), 0);
                end else begin
                    logic [2:0] e;
                    e = eq.pop_front();
                    chk(err_code == e, code_req(e), int'(err_code), int'(e));
                end
            end
            if (as_valid && as_ready) begin
                if (aq.size() == 0) begin
                    chk(0, "R8", int'({as_addr, as_kind}), 0);
                end else begin
                    logic [9:0] x;
                    x = aq.pop_front();
                    chk({as_addr, as_kind} == x, "R7 R12", int'({as_addr, as_kind}), int'(x));
                end
            end
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int first;
        for (int i = 0; i < 4; i++) begin mtag[i] = 0; mst[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(tr_ready == 1, "R1", int'(tr_ready), 1);
        chk(as_valid == 0, "R1", int'(as_valid), 0);
        chk(err_valid == 0, "R1", int'(err_valid), 0);

        // R2 R7 R8: legal sequences
        send(8'h10, 3'd0, 0);
        send(8'h10, 3'd1, 0);
        send(8'h10, 3'd0, 0);
        send(8'h10, 3'd2, 0);
        send(8'h10, 3'd4, 0);
        send(8'h22, 3'd1, 0);
        send(8'h22, 3'd3, 0);
        send(8'h33, 3'd2, 0);
        // R3 R4 R5 R6: mismatches leave the entry unchanged
        send(8'h44, 3'd0, 1);
        send(8'h44, 3'd0, 0);
        send(8'h44, 3'd1, 2);
        send(8'h44, 3'd1, 3);
        send(8'h44, 3'd1, 4);
        send(8'h44, 3'd1, 0);
        // R11: alias at index 0 replaces tag of 0x44
        send(8'h84, 3'd0, 0);
        send(8'h44, 3'd0, 0);
        repeat (4) @(negedge clk);

        // R9: backpressure with full buffer
        @(posedge clk); #1 as_ready = 0;
        send(8'h11, 3'd0, 0);
        send(8'h21, 3'd1, 0);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk(tr_ready == 0, "R9", int'(tr_ready), 0);
            @(negedge clk);
        end
        @(posedge clk); #1 as_ready = 1;
        send(8'h12, 3'd0, 0);
        repeat (4) @(negedge clk);

        // R10: timeout after WDL cycles
        eq.push_back(3'd4);
        pend_req = 1;
        first = 0;
        for (int i = 1; i <= WDL + 4; i++) begin
            @(negedge clk);
            if (err_valid && first == 0) first = i;
        end
        chk(first == WDL, "R10", first, WDL);
        pend_req = 0;
        @(negedge clk);

        // R10: accepted record restarts the count
        pend_req = 1;
        repeat (6) @(negedge clk);
        eq.push_back(3'd4);
        send(8'h33, 3'd2, 0);
        first = 0;
        for (int i = 1; i <= WDL + 4; i++) begin
            @(negedge clk);
            if (err_valid && first == 0) first = i;
        end
        chk(first == WDL, "R10", first, WDL);
        pend_req = 0;

        repeat (10) @(negedge clk);
        chk(aq.size() == 0, "R7", aq.size(), 0);
        chk(eq.size() == 0, "R3", eq.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule